// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block plans the memory side of an instruction that loads or stores several registers at once. A single start strobe presents a 16-bit register-select mask, a base address, an up/down direction bit, a pre/post indexing bit, a write-back bit and a load/store bit. The block captures all of these in that cycle. It then emits one memory beat per selected register, and each beat carries the register index, a word address and a write strobe. Each beat waits on a valid/ready handshake to a memory port.

The beats always run from the lowest selected register to the highest, at addresses that rise by one word. The direction bit only decides where this run of addresses starts: above the base or below it. A done pulse marks the final accepted beat. When write-back is requested, the new base value appears on a one-cycle strobe in the cycle after that beat. On a store that includes register 15, the block flags that beat and supplies the value to store in its place, which is the instruction address plus 12. An empty mask is rejected with an error pulse, and no beat is produced.

Top module: `blk_xfer_seq`

## Requirements
- R1: Beats are issued only for registers whose mask bit is set (bit i selects register i), one beat per register, in strictly increasing index order, so register 15 is always last when selected.
- R2: The address of each beat is the previous beat's address plus 4, so the lowest selected register sits at the lowest address of the block.
- R3: With N selected registers, the first beat's address is base when up=1 and pre=0, base+4 when up=1 and pre=1, base-4N+4 when up=0 and pre=0, and base-4N when up=0 and pre=1.
- R4: When the write-back bit is 1, wb_valid_o is high for exactly one cycle, the cycle after the final beat is accepted, and wb_base_o is base+4N when up=1 or base-4N when up=0. When the write-back bit is 0, wb_valid_o stays low.
- R5: A beat's index, address and strobes stay unchanged while beat_valid_o is high and beat_ready_i is low. The sequence advances only on a cycle in which both are high.
- R6: done_o is high in the same cycle as the final accepted beat and in no other cycle.
- R7: On a store, the beat for register 15 raises beat_use_pc_o, and pc_store_o equals the captured instruction address plus 12. beat_use_pc_o stays low on every other beat and on every load.
- R8: beat_write_o is 1 on every beat of a store (load bit 0) and 0 on every beat of a load (load bit 1).
- R9: A start with an all-zero mask raises err_o for one cycle, the cycle after the start. It issues no beat and leaves the block idle.
- R10: A start is taken only while busy_o is low. A start strobe during a sequence is ignored, and the request inputs may change after the start without affecting the sequence in progress.
- R11: After reset, busy_o, beat_valid_o, done_o, wb_valid_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| mask_i | input | 16 | Register-select mask, bit i selects register i |
| base_i | input | 32 | Base address |
| pre_i | input | 1 | 1: step before each transfer; 0: step after |
| up_i | input | 1 | 1: block above base; 0: block below base |
| wb_i | input | 1 | 1: report the updated base for write-back |
| load_i | input | 1 | 1: load (read beats); 0: store (write beats) |
| instr_addr_i | input | 32 | Address of the requesting instruction |
| busy_o | output | 1 | A sequence is in progress |
| err_o | output | 1 | One-cycle pulse: empty mask rejected |
| beat_valid_o | output | 1 | Current beat is valid |
| beat_ready_i | input | 1 | Memory port accepts the current beat |
| beat_idx_o | output | 4 | Register index of the current beat |
| beat_addr_o | output | 32 | Word address of the current beat |
| beat_write_o | output | 1 | 1: write beat, 0: read beat |
| beat_use_pc_o | output | 1 | Current beat stores register 15; use pc_store_o as data |
| pc_store_o | output | 32 | Instruction address plus 12 |
| done_o | output | 1 | High with the final accepted beat |
| wb_valid_o | output | 1 | One-cycle write-back strobe |
| wb_base_o | output | 32 | Updated base value |

## Verification
The sweep tries every single-register mask, every mask confined to the low four registers, and a set of wide and sparse patterns such as all ones, alternating bits and the two end registers. These are run under all sixteen combinations of the pre, up, write-back and load bits. Single-register masks separate the four start-address rules, because only the pre/post step differs there. Wide masks expose a wrong N in the down-direction start and in the write-back value, and sparse masks catch skipped or repeated indices. The ready line follows a stall pattern, so beats are held as well as accepted. Some runs also raise a second start and alter every request input mid-sequence, which checks input capture and the idle-only acceptance.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic [0:0] {
    BX_IDLE = 1'b0,
    BX_RUN  = 1'b1
  } bx_state_e;

endpackage

// File: rtl/bx_pick.sv
// Lowest-set-bit picker over the pending register mask.
module bx_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend_i,
  output logic [IW-1:0]   idx_o,
  output logic [NREG-1:0] hit_oh_o,
  output logic            last_o
);

  // below[i] is set when some bit under position i is pending
  logic [NREG:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < NREG; g++) begin : g_chain
    assign below[g+1]  = below[g] | pend_i[g];
    assign hit_oh_o[g] = pend_i[g] & ~below[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_oh_o[i]) idx_o = IW'(i);
    end
  end

  // only the picked bit remains pending
  assign last_o = below[NREG] && ((pend_i & ~hit_oh_o) == '0);

endmodule

// File: rtl/bx_addr_plan.sv
// Start address and final base from the request, before capture.
module bx_addr_plan #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            pre_i,
  input  logic            up_i,
  output logic [AW-1:0]   first_addr_o,
  output logic [AW-1:0]   final_base_o,
  output logic            empty_o
);

  localparam int CW = $clog2(NREG + 1);

  function automatic logic [CW-1:0] count_ones(input logic [NREG-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  function automatic logic [AW-1:0] span_bytes(input logic [CW-1:0] n);
    return AW'(n) * AW'(WORD_BYTES);
  endfunction

  // lowest address of the block for the chosen direction and step timing
  function automatic logic [AW-1:0] low_addr(input logic [AW-1:0] b,
                                             input logic [AW-1:0] span,
                                             input logic pre, input logic up);
    logic [AW-1:0] step;
    step = AW'(WORD_BYTES);
    if (up) return pre ? (b + step) : b;
    else    return pre ? (b - span) : (b - span + step);
  endfunction

  function automatic logic [AW-1:0] end_base(input logic [AW-1:0] b,
                                             input logic [AW-1:0] span,
                                             input logic up);
    return up ? (b + span) : (b - span);
  endfunction

  logic [CW-1:0] n_sel;
  logic [AW-1:0] span;

  assign n_sel        = count_ones(mask_i);
  assign span         = span_bytes(n_sel);
  assign first_addr_o = low_addr(base_i, span, pre_i, up_i);
  assign final_base_o = end_base(base_i, span, up_i);
  assign empty_o      = (mask_i == '0);

endmodule

// File: rtl/bx_seq_fsm.sv
// Two-state control: idle until a valid start, run until the last beat fires.
module bx_seq_fsm
  import bx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic empty_i,
  input  logic fire_i,
  input  logic last_i,
  output logic run_o,
  output logic take_o,
  output logic err_o
);

  bx_state_e state_q, state_d;
  logic      err_q;

  assign take_o = (state_q == BX_IDLE) && start_i && !empty_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      BX_IDLE: if (take_o) state_d = BX_RUN;
      BX_RUN:  if (fire_i && last_i) state_d = BX_IDLE;
      default: state_d = BX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BX_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == BX_IDLE) && start_i && empty_i;
    end
  end

  assign run_o = (state_q == BX_RUN);
  assign err_o = err_q;

endmodule

// File: rtl/blk_xfer_seq.sv
// Multi-register transfer sequencer: one handshaked beat per selected register.
module blk_xfer_seq #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int PC_AHEAD   = 12,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            pre_i,
  input  logic            up_i,
  input  logic            wb_i,
  input  logic            load_i,
  input  logic [AW-1:0]   instr_addr_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            beat_valid_o,
  input  logic            beat_ready_i,
  output logic [IW-1:0]   beat_idx_o,
  output logic [AW-1:0]   beat_addr_o,
  output logic            beat_write_o,
  output logic            beat_use_pc_o,
  output logic [AW-1:0]   pc_store_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_base_o
);

  // captured request
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   fbase_q;
  logic [AW-1:0]   pcval_q;
  logic            wb_q;
  logic            load_q;
  logic            wbs_q;

  // named internal events
  logic            run;
  logic            take;
  logic            empty;
  logic            fire;
  logic            last;
  logic [NREG-1:0] hit_oh;
  logic [IW-1:0]   pick_idx;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_base;

  bx_addr_plan #(
    .AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
  ) u_plan (
    .mask_i       (mask_i),
    .base_i       (base_i),
    .pre_i        (pre_i),
    .up_i         (up_i),
    .first_addr_o (first_addr),
    .final_base_o (final_base),
    .empty_o      (empty)
  );

  bx_pick #(.NREG(NREG)) u_pick (
    .pend_i   (pend_q),
    .idx_o    (pick_idx),
    .hit_oh_o (hit_oh),
    .last_o   (last)
  );

  bx_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .empty_i (empty),
    .fire_i  (fire),
    .last_i  (last),
    .run_o   (run),
    .take_o  (take),
    .err_o   (err_o)
  );

  assign fire = run && beat_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      addr_q  <= '0;
      fbase_q <= '0;
      pcval_q <= '0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      wbs_q   <= 1'b0;
    end else begin
      wbs_q <= fire && last && wb_q;
      if (take) begin
        pend_q  <= mask_i;
        addr_q  <= first_addr;
        fbase_q <= final_base;
        pcval_q <= instr_addr_i + AW'(PC_AHEAD);
        wb_q    <= wb_i;
        load_q  <= load_i;
      end else if (fire) begin
        pend_q <= pend_q & ~hit_oh;
        addr_q <= addr_q + AW'(WORD_BYTES);
      end
    end
  end

  assign busy_o        = run;
  assign beat_valid_o  = run;
  assign beat_idx_o    = pick_idx;
  assign beat_addr_o   = addr_q;
  assign beat_write_o  = !load_q;
  assign beat_use_pc_o = run && !load_q && hit_oh[NREG-1];
  assign pc_store_o    = pcval_q;
  assign done_o        = fire && last;
  assign wb_valid_o    = wbs_q;
  assign wb_base_o     = fbase_q;

endmodule

// File: rtl/bx_chk.sv
module bx_chk #(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          err_o,
  input logic          beat_valid_o,
  input logic          beat_ready_i,
  input logic [IW-1:0] beat_idx_o,
  input logic [AW-1:0] beat_addr_o,
  input logic          done_o,
  input logic          wb_valid_o,
  input logic          fire,
  input logic          last
);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o) && $stable(beat_idx_o));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> beat_addr_o == $past(beat_addr_o) + AW'(WORD_BYTES));

  // R1
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> beat_idx_o > $past(beat_idx_o));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> beat_valid_o && beat_ready_i ##1 !busy_o);

  // R4
  wb_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> $past(done_o));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !beat_valid_o && !busy_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !beat_valid_o && !done_o);

endmodule

bind blk_xfer_seq bx_chk #(
  .AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_idx_o   (beat_idx_o),
  .beat_addr_o  (beat_addr_o),
  .done_o       (done_o),
  .wb_valid_o   (wb_valid_o),
  .fire         (fire),
  .last         (last)
);

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic        pre_i = 1'b0, up_i = 1'b0, wb_i = 1'b0, load_i = 1'b0;
  logic [31:0] instr_addr_i = '0;
  logic        busy_o, err_o, beat_valid_o;
  logic        beat_ready_i = 1'b0;
  logic [3:0]  beat_idx_o;
  logic [31:0] beat_addr_o;
  logic        beat_write_o, beat_use_pc_o;
  logic [31:0] pc_store_o;
  logic        done_o, wb_valid_o;
  logic [31:0] wb_base_o;

  int errors = 0;
  int checks = 0;
  int stall_seed = 0;

  always #(CLK_P/2) clk = ~clk;

  blk_xfer_seq i_blk_xfer_seq (
    .clk, .rst_n, .start_i, .mask_i, .base_i, .pre_i, .up_i, .wb_i, .load_i,
    .instr_addr_i, .busy_o, .err_o, .beat_valid_o, .beat_ready_i, .beat_idx_o,
    .beat_addr_o, .beat_write_o, .beat_use_pc_o, .pc_store_o, .done_o,
    .wb_valid_o, .wb_base_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int next_bit(input logic [15:0] m, input int from);
    for (int i = from; i < 16; i++) if (m[i]) return i;
    return 16;
  endfunction

  function automatic logic [15:0] pick_mask(input int i);
    if (i < 16) return 16'(1) << i;
    if (i < 31) return 16'(i - 15);
    case (i)
      31: return 16'hFFFF;
      32: return 16'h00A2;
      33: return 16'h8001;
      34: return 16'hAAAA;
      35: return 16'h5555;
      36: return 16'h7FFE;
      default: return 16'hF00F;
    endcase
  endfunction

  task automatic run_req(input logic [15:0] m, input logic [31:0] b,
                         input bit pre, input bit up, input bit wb, input bit ld,
                         input bit poke);
    int n = 0;
    int k = 0;
    int cyc = 0;
    int ei;
    logic [31:0] lo, wexp, ia;
    for (int i = 0; i < 16; i++) if (m[i]) n++;
    // block occupies n words; lowest register at lowest word
    if (up) lo = pre ? b + 32'd4 : b;
    else    lo = b - 32'(4 * n) + (pre ? 32'd0 : 32'd4);
    wexp = up ? b + 32'(4 * n) : b - 32'(4 * n);
    ia = b ^ 32'h0BAD_0000;
    @(negedge clk);
    start_i = 1'b1; mask_i = m; base_i = b; pre_i = pre; up_i = up;
    wb_i = wb; load_i = ld; instr_addr_i = ia;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble request inputs after the start
    mask_i = ~m; base_i = ~b; pre_i = !pre; up_i = !up; wb_i = !wb;
    load_i = !ld; instr_addr_i = ~ia;
    ei = next_bit(m, 0);
    while (k < n && cyc < 200) begin
      beat_ready_i = ((cyc + stall_seed) % 3) != 0;
      start_i = poke && (cyc == 1);
      if (poke && cyc == 1) mask_i = 16'h0001;
      #1;
      chk(beat_valid_o && busy_o, "R10", "beat valid during sequence", 32'(beat_valid_o), 32'd1);
      chk(beat_idx_o == 4'(ei), "R1", "beat index", 32'(beat_idx_o), 32'(ei));
      chk(beat_addr_o == lo + 32'(4 * k), (k == 0) ? "R3" : "R2", "beat address",
          beat_addr_o, lo + 32'(4 * k));
      chk(beat_write_o == !ld, "R8", "write strobe", 32'(beat_write_o), 32'(!ld));
      chk(beat_use_pc_o == (ei == 15 && !ld), "R7", "pc substitution flag",
          32'(beat_use_pc_o), 32'(ei == 15 && !ld));
      if (ei == 15 && !ld)
        chk(pc_store_o == ia + 32'd12, "R7", "pc store value", pc_store_o, ia + 32'd12);
      chk(done_o == (beat_ready_i && k == n - 1), "R6", "done pulse",
          32'(done_o), 32'(beat_ready_i && k == n - 1));
      if (beat_ready_i) begin
        k++;
        ei = next_bit(m, ei + 1);
      end
      // R5: a stalled beat must reappear unchanged on the next cycle
      cyc++;
      @(negedge clk);
      start_i = 1'b0;
    end
    beat_ready_i = 1'b0;
    #1;
    chk(k == n, "R1", "beat count", 32'(k), 32'(n));
    chk(!busy_o && !beat_valid_o, "R1", "no beat after last", 32'(beat_valid_o), 32'd0);
    chk(wb_valid_o == wb, "R4", "write-back strobe", 32'(wb_valid_o), 32'(wb));
    if (wb) chk(wb_base_o == wexp, "R4", "write-back value", wb_base_o, wexp);
    @(negedge clk);
    #1;
    chk(!wb_valid_o, "R4", "write-back strobe single cycle", 32'(wb_valid_o), 32'd0);
  endtask

  task automatic empty_req(input logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; mask_i = '0; base_i = b;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(err_o, "R9", "error pulse on empty mask", 32'(err_o), 32'd1);
    chk(!beat_valid_o && !busy_o, "R9", "no beat on empty mask", 32'(beat_valid_o), 32'd0);
    @(negedge clk);
    #1;
    chk(!err_o && !beat_valid_o, "R9", "error single cycle", 32'(err_o), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 2);
    #1;
    chk(!busy_o && !beat_valid_o && !done_o && !wb_valid_o && !err_o, "R11",
        "reset outputs", {27'd0, busy_o, beat_valid_o, done_o, wb_valid_o, err_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy_o && !beat_valid_o, "R11", "idle after reset", 32'(busy_o), 32'd0);

    empty_req(32'h0000_1000);

    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int mi = 0; mi < 38; mi++) begin
        stall_seed = cfg + mi;
        run_req(pick_mask(mi), 32'h0000_1000 + 32'(cfg) * 32'h100,
                cfg[0], cfg[1], cfg[2], cfg[3], (mi % 5) == 0);
      end
    end

    // base near zero: down direction wraps below address 0
    run_req(16'hFFFF, 32'h0000_0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    empty_req(32'hFFFF_FFF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule